// File: doc/BRIEF.md
# SPI Register and FIFO Gateway

This block is an SPI slave (mode 0) that gives a host access to a byte-wide register space and to a 64-byte FIFO. An active-low select frames each command. The first byte of a command holds a direction bit and a 7-bit address. Every byte after it is a data byte that is either written to that address or read from it. During a burst the address advances by one after each data byte. The top address is the exception: it never advances, and it acts as a gateway that streams bytes into the FIFO on writes and out of the FIFO on reads.

The SPI pins are sampled with the system clock. They pass through two-stage synchronizers before edge detection, so the serial clock must run well below the system clock: each SCK phase must last at least six system clocks. One bit of the control register (address 0x08) holds the FIFO in its cleared state. Writing 1 and then 0 to that bit flushes the FIFO. The register contents carry no further meaning inside this block.

Top module: `spi_reg_gateway`

## Requirements
- R1: After reset, miso_o and fifo_ovf_o are low, every register reads 0x00, and the FIFO is empty.
- R2: Each byte is 8 bits, MSB first. MOSI is sampled on the rising SCK edge and MISO changes after the falling edge. While select is high, MISO is low. One low period of select is one command.
- R3: In the first byte of a command, bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits 6:0 give the start address. For example, the bytes 0x87, 0x01 store 0x01 in register 0x07.
- R4: During a read, the byte slot that follows the command byte carries the value at the addressed location.
- R5: In a burst, the address advances by one after each data byte. A burst that starts at 0x7E moves on to the gateway address 0x7F.
- R6: At address 0x7F the address stays fixed. Written bytes are pushed into the FIFO, and read bytes are popped from it in the order they were pushed.
- R7: The FIFO holds 64 bytes. A byte written while the FIFO is full is dropped and sets fifo_ovf_o. fifo_ovf_o stays high until the FIFO is cleared.
- R8: Reading the gateway while the FIFO is empty returns 0x00 and leaves the FIFO unchanged.
- R9: While bit 1 of register 0x08 is 1, the FIFO is held empty, fifo_ovf_o is low, and pushes are dropped. Writing 1 and then 0 to this bit therefore flushes the FIFO.
- R10: Raising select discards a partial byte without writing it. The next command is decoded from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI serial clock, idles low |
| csn_i | input | 1 | SPI select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| fifo_ovf_o | output | 1 | Sticky flag: a write was made to the full FIFO |

## Verification
The bench fills the FIFO to exactly 64 bytes, then pushes one more. It checks that the overflow flag rises only on that extra byte and that the extra byte is never read back. A design with an off-by-one depth would raise the flag early or return a corrupted sequence. The bench also bursts across 0x7E into the gateway and reads the gateway past empty. A design that advanced the address past 0x7F, or that popped on an empty FIFO, would return wrong bytes. Last, it drops select in the middle of a byte and then flushes the FIFO with the control bit. A design that kept stale bit counts, or that ignored the held clear, would write registers it must not touch or leave old FIFO data behind.

// File: rtl/spi_gw_pkg.sv
package spi_gw_pkg;
  localparam int unsigned SPI_BYTE_W = 8;
  localparam int unsigned SPI_ADDR_W = 7;
  typedef logic [SPI_BYTE_W-1:0] spi_byte_t;
endpackage

// File: rtl/spi_gw_sync.sv
module spi_gw_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/spi_gw_shift.sv
module spi_gw_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          mosi_i,
  input  logic [DW-1:0] load_i,
  output logic          byte_valid_o,
  output logic          byte_first_o,
  output logic [DW-1:0] byte_o,
  output logic          miso_o
);
  localparam int unsigned CNT_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    rx_q, tx_q;
  logic             first_q, ld_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      rx_q         <= '0;
      tx_q         <= '0;
      first_q      <= 1'b1;
      ld_pend_q    <= 1'b0;
      byte_valid_o <= 1'b0;
      byte_first_o <= 1'b0;
      byte_o       <= '0;
    end else if (!active_i) begin
      cnt_q        <= '0;
      tx_q         <= '0;
      first_q      <= 1'b1;
      ld_pend_q    <= 1'b0;
      byte_valid_o <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      if (rise_i) begin
        rx_q  <= {rx_q[DW-2:0], mosi_i};
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          byte_valid_o <= 1'b1;
          byte_first_o <= first_q;
          byte_o       <= {rx_q[DW-2:0], mosi_i};
          first_q      <= 1'b0;
          ld_pend_q    <= 1'b1;
        end
      end
      if (fall_i) begin
        // next outgoing byte is fetched only after the address is updated
        if (ld_pend_q) begin
          tx_q      <= load_i;
          ld_pend_q <= 1'b0;
        end else begin
          tx_q <= {tx_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign miso_o = tx_q[DW-1];
endmodule

// File: rtl/spi_gw_fifo.sv
module spi_gw_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [DW-1:0]    din_i,
  input  logic             pop_i,
  output logic [DW-1:0]    head_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic             full, do_push, do_pop;

  assign full    = (cnt_o == CNT_FULL);
  assign empty_o = (cnt_o == '0);
  assign do_push = push_i && !full && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign head_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_o    <= '0;
      ovf_o    <= 1'b0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_o    <= '0;
      ovf_o    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      cnt_o <= cnt_o + 1'b1;
      else if (do_pop && !do_push) cnt_o <= cnt_o - 1'b1;
      if (push_i && full) ovf_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= din_i;
  end
endmodule

// File: rtl/spi_reg_gateway.sv
module spi_reg_gateway
  import spi_gw_pkg::*;
#(
  parameter int unsigned ADDR_W     = SPI_ADDR_W,
  parameter int unsigned DW         = SPI_BYTE_W,
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned CTRL_ADDR  = 8,
  parameter int unsigned CLR_BIT    = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic fifo_ovf_o
);
  localparam int unsigned NREG   = 2 ** ADDR_W;
  localparam logic [ADDR_W-1:0] GATE = ADDR_W'(NREG - 1);
  localparam int unsigned FCNT_W = $clog2(FIFO_DEPTH + 1);

  logic [2:0] pin_s;
  logic       sck_s, csn_s, mosi_s, sck_d_q;
  logic       active, rise, fall;

  spi_gw_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mosi_i, csn_i, sck_i}),
    .q_o   (pin_s)
  );
  assign {mosi_s, csn_s, sck_s} = pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d_q <= 1'b0;
    else         sck_d_q <= sck_s;
  end

  assign active = !csn_s;
  assign rise   = sck_s && !sck_d_q;
  assign fall   = !sck_s && sck_d_q;

  logic          bv, bfirst, tx_bit;
  logic [DW-1:0] rx_byte, rd_byte;

  spi_gw_shift #(.DW(DW)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .rise_i      (rise),
    .fall_i      (fall),
    .mosi_i      (mosi_s),
    .load_i      (rd_byte),
    .byte_valid_o(bv),
    .byte_first_o(bfirst),
    .byte_o      (rx_byte),
    .miso_o      (tx_bit)
  );

  logic [ADDR_W-1:0]         addr_q, addr_nxt;
  logic                      is_wr_q, data_bv, reg_we;
  logic [NREG-1:0][DW-1:0]   regs_q;

  assign data_bv  = bv && !bfirst;
  assign addr_nxt = (addr_q == GATE) ? GATE : addr_q + 1'b1;
  assign reg_we   = data_bv && is_wr_q && (addr_q != GATE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      is_wr_q <= 1'b0;
    end else if (bv && bfirst) begin
      addr_q  <= rx_byte[ADDR_W-1:0];
      is_wr_q <= rx_byte[DW-1];
    end else if (data_bv) begin
      addr_q  <= addr_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     regs_q         <= '0;
    else if (reg_we) regs_q[addr_q] <= rx_byte;
  end

  logic                fifo_push, fifo_pop, fifo_clr, fifo_empty;
  logic [DW-1:0]       fifo_head;
  logic [FCNT_W-1:0]   fifo_cnt;

  assign fifo_push = data_bv && is_wr_q && (addr_q == GATE);
  assign fifo_pop  = data_bv && !is_wr_q && (addr_q == GATE);
  assign fifo_clr  = regs_q[CTRL_ADDR][CLR_BIT];

  spi_gw_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fifo_clr),
    .push_i (fifo_push),
    .din_i  (rx_byte),
    .pop_i  (fifo_pop),
    .head_o (fifo_head),
    .empty_o(fifo_empty),
    .cnt_o  (fifo_cnt),
    .ovf_o  (fifo_ovf_o)
  );

  always_comb begin
    if (addr_q == GATE) rd_byte = fifo_empty ? '0 : fifo_head;
    else                rd_byte = regs_q[addr_q];
  end

  assign miso_o = tx_bit;
endmodule

// File: rtl/spi_gw_checker.sv
module spi_gw_checker #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             pop_i,
  input logic             clr_i,
  input logic             ovf_i,
  input logic [CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= FULL); // R7
  AST_OVF_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !clr_i && cnt_i == FULL |=> ovf_i); // R7
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i && !clr_i && cnt_i == FULL |=> cnt_i == FULL); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i && !clr_i |=> ovf_i); // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_i == '0 && !ovf_i); // R9
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && cnt_i == '0 |=> cnt_i == '0); // R8
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + 1'b1
                || cnt_i + 1'b1 == $past(cnt_i))); // R6
endmodule

bind spi_reg_gateway spi_gw_checker #(.DEPTH(FIFO_DEPTH), .CNT_W(FCNT_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .push_i(fifo_push),
  .pop_i (fifo_pop),
  .clr_i (fifo_clr),
  .ovf_i (fifo_ovf_o),
  .cnt_i (fifo_cnt)
);

// File: tb/spi_reg_gateway_bench.sv
`timescale 1ns/1ps
module spi_reg_gateway_bench;
  localparam int H = 8;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso, ovf;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  logic [7:0] exp_q[$], got_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  spi_reg_gateway u_spi_reg_gateway (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn),
    .mosi_i(mosi), .miso_o(miso), .fifo_ovf_o(ovf)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0 && exp_q.size() > 0)
      check8(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
  end

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      wait_clk(H);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
  endtask

  task automatic cs_low();
    csn = 1'b0;
    wait_clk(H);
  endtask

  task automatic cs_high();
    wait_clk(H);
    csn = 1'b1;
    wait_clk(2 * H);
  endtask

  task automatic wr_burst(input logic [6:0] addr, input bq_t data);
    logic [7:0] rx;
    cs_low();
    spi_bits({1'b1, addr}, 8, rx);
    foreach (data[i]) spi_bits(data[i], 8, rx);
    cs_high();
  endtask

  task automatic rd_burst(input logic [6:0] addr, input bq_t expv, input string req);
    logic [7:0] rx;
    cs_low();
    spi_bits({1'b0, addr}, 8, rx);
    foreach (expv[i]) begin
      spi_bits(8'h00, 8, rx);
      exp_q.push_back(expv[i]);
      tag_q.push_back(req);
      got_q.push_back(rx);
    end
    cs_high();
  endtask

  task automatic finish_run();
    wait_clk(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    bq_t fill, fexp;
    logic [7:0] rx;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1 reset state
    check8("R1 miso", {7'd0, miso}, 8'h00);
    check8("R1 ovf", {7'd0, ovf}, 8'h00);
    rd_burst(7'h07, '{8'h00}, "R1 reg07");
    rd_burst(7'h08, '{8'h00}, "R1 reg08");
    rd_burst(7'h7F, '{8'h00}, "R1 fifo empty");

    // R3 single write, R2 readback framing, R4 read slot
    wr_burst(7'h07, '{8'h01});
    rd_burst(7'h07, '{8'h01}, "R3 write 0x87 0x01");
    wr_burst(7'h20, '{8'hA5});
    rd_burst(7'h20, '{8'hA5}, "R2 msb-first byte");
    check8("R2 miso idle", {7'd0, miso}, 8'h00);

    // R5 burst increment
    wr_burst(7'h10, '{8'hAA, 8'hBB, 8'hCC});
    rd_burst(7'h10, '{8'hAA, 8'hBB, 8'hCC}, "R5 burst read");
    rd_burst(7'h0F, '{8'h00, 8'hAA}, "R4 burst from 0x0F");

    // R5 crossing into gateway, R6 fixed gateway
    wr_burst(7'h7E, '{8'h3C, 8'h11, 8'h22});
    rd_burst(7'h7E, '{8'h3C}, "R5 reg 0x7E");
    rd_burst(7'h7F, '{8'h11, 8'h22}, "R6 fifo order");

    // R7 fill to depth and overflow
    wr_burst(7'h08, '{8'h02});
    wr_burst(7'h08, '{8'h00});
    check8("R9 ovf after clear", {7'd0, ovf}, 8'h00);
    for (int i = 0; i < 64; i++) fill.push_back(8'(i * 3 + 1));
    wr_burst(7'h7F, fill);
    check8("R7 no ovf at 64", {7'd0, ovf}, 8'h00);
    wr_burst(7'h7F, '{8'hEE});
    check8("R7 ovf on 65th", {7'd0, ovf}, 8'h01);
    fexp = fill;
    fexp.push_back(8'h00);
    rd_burst(7'h7F, fexp, "R7 contents, R8 empty read");
    rd_burst(7'h7F, '{8'h00}, "R8 empty again");
    check8("R7 ovf sticky", {7'd0, ovf}, 8'h01);

    // R9 clear control bit
    wr_burst(7'h7F, '{8'h44, 8'h55});
    wr_burst(7'h08, '{8'h02});
    check8("R9 ovf cleared", {7'd0, ovf}, 8'h00);
    wr_burst(7'h7F, '{8'h77});
    wr_burst(7'h08, '{8'h00});
    rd_burst(7'h08, '{8'h00}, "R9 ctrl readback");
    rd_burst(7'h7F, '{8'h00}, "R9 fifo flushed");

    // R10 partial byte abort
    cs_low();
    spi_bits(8'h87, 8, rx);
    spi_bits(8'hFF, 5, rx);
    cs_high();
    rd_burst(7'h07, '{8'h01}, "R10 no partial write");
    cs_low();
    spi_bits(8'hFF, 3, rx);
    cs_high();
    wr_burst(7'h07, '{8'h5A});
    rd_burst(7'h07, '{8'h5A}, "R10 fresh decode");

    wait_clk(4);
    done = 1'b1;
    finish_run();
  end
endmodule